// File: doc/BRIEF.md
# Receive PHY Bring-Up Sequencer

This block brings a receive PHY with one to four data lanes out of reset and into normal operation. A single start pulse samples a lane count and a line rate in Mbps. The block first finds a 6-bit frequency-band code for that rate in a built-in list of ascending upper bounds. It refuses the request if the rate has no usable code or the lane count is out of range.

If the request is accepted, the block drives the static lane-control outputs and pulses the PHY test-port clear with timed waits. It then programs the PHY through its byte-wide test port with a fixed script of seven code/data transactions and reports completion. A stop pulse aborts any activity and turns every lane off.

All waits are measured in clock cycles. The clear pulse and the wait after it last `CLR_US * CYC_PER_US` cycles each. Every test-port step lasts `STEP_CYC` cycles.

Top module: `rxphy_bringup`

## Requirements
- R1: The band code is taken from the first entry, in ascending order of upper bound, whose bound is at least the rate. Each code is the sub-index times 16 plus the band nibble. The bounds for each nibble are:
  - nibble 0: 89, 99, 109
  - nibble 1: 129, 139, 149
  - nibble 2: 169, 179, 199
  - nibble 3: 219, 239, 249
  - nibble 4: 269, 299
  - nibble 5: 329, 359, 399
  - nibble 6: 449, 499
  - nibble 7: 549, 599
  - nibble 8: 649, 699
  - nibble 9: 749, 799, 849, 899
  - nibble 10: 949, 999, 1049, 1099
  - nibble 11: 1149, 1199, 1249, 1299
  - nibble 12: 1349, 1399, 1449, 1500
- R2: A request is rejected in three cases: the lane count is 0 or above `MAX_LANES`, no entry matches, or the matched code is zero (any rate up to 89). A rejection gives a one-cycle `err_o` pulse. It arrives one cycle after acceptance for a bad lane count, and otherwise after one cycle per entry examined (39 if none matches). A rejection leaves `lane_en_o` and the test port unchanged.
- R3: On acceptance the outputs are set as follows. `force_rx_o`, `force_stop_o` and `turn_req_o` go to 0. `turn_dis_o` goes to all ones. `lane_en_o` gets its lowest N bits set for N lanes.
- R4: Before any write, `test_clk_o` goes high. Then `test_clr_o` is high for exactly `CLR_US*CYC_PER_US` cycles. After it falls, the first test-clock fall follows `CLR_US*CYC_PER_US + STEP_CYC` cycles later.
- R5: Each transaction runs in this order:
  - the code is placed on `test_din_o` with `test_en_o` high;
  - `test_clk_o` falls while `test_en_o` is high;
  - `test_en_o` drops;
  - the data is placed on `test_din_o`;
  - `test_clk_o` rises while `test_en_o` is low.
- R6: The seven transactions, in this order, are:
  - code 0x34 with data 0x00;
  - codes 0x44, 0x54, 0x84 and 0x94, each with data equal to the band code shifted left by one;
  - code 0x75 with data 0x04;
  - code 0x00 with data 0x00.
- R7: Each test-port step lasts `STEP_CYC` cycles. For an entry at index k, the `done_o` pulse comes `k + 1 + 37*STEP_CYC + 2*CLR_US*CYC_PER_US` cycles after the start edge.
- R8: `busy_o` is high from the cycle after an accepted start until `done_o` or `err_o`. `done_o` is a one-cycle pulse. A start while busy is ignored.
- R9: `stop_i` clears `lane_en_o` and `busy_o` on the next edge, from any state. A stop ends a bring-up with no `done_o`, and it takes priority over a simultaneous start.
- R10: After reset, these outputs are all 0: `busy_o`, `done_o`, `err_o`, the lane controls, `test_clk_o`, `test_clr_o`, `test_en_o` and `test_din_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| start_i | input | 1 | bring-up request pulse |
| stop_i | input | 1 | power-down pulse |
| lanes_i | input | LW | requested lane count |
| rate_i | input | RATE_W | line rate in Mbps |
| busy_o | output | 1 | sequence in progress |
| done_o | output | 1 | bring-up complete pulse |
| err_o | output | 1 | request rejected pulse |
| force_rx_o | output | MAX_LANES | force receive mode per lane |
| force_stop_o | output | MAX_LANES | force stop state per lane |
| turn_req_o | output | MAX_LANES | turnaround request per lane |
| turn_dis_o | output | MAX_LANES | turnaround disable per lane |
| lane_en_o | output | MAX_LANES | lane enable mask |
| test_clk_o | output | 1 | PHY test clock |
| test_clr_o | output | 1 | PHY test clear |
| test_en_o | output | 1 | PHY test enable |
| test_din_o | output | 8 | PHY test data in |

## Verification
A wrong scan index or band code appears only at the end of a bring-up. It shows as wrong data in transactions two to five and as a `done_o` pulse that comes too early or too late. A slip in the step timer shifts every test-port edge and moves `done_o` by a multiple of `STEP_CYC`. A wrong phase order shows at the first test-clock edge, which falls with enable low or rises with enable high. A missed stop shows one cycle later as a lane mask that stays set.

// File: rtl/rxphy_bringup.sv
module rxphy_bringup #(
  parameter int CYC_PER_US = 125,
  parameter int CLR_US     = 100,
  parameter int STEP_CYC   = 4,
  parameter int MAX_LANES  = 4,
  parameter int RATE_W     = 11,
  localparam int LW        = $clog2(MAX_LANES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic                 stop_i,
  input  logic [LW-1:0]        lanes_i,
  input  logic [RATE_W-1:0]    rate_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 err_o,
  output logic [MAX_LANES-1:0] force_rx_o,
  output logic [MAX_LANES-1:0] force_stop_o,
  output logic [MAX_LANES-1:0] turn_req_o,
  output logic [MAX_LANES-1:0] turn_dis_o,
  output logic [MAX_LANES-1:0] lane_en_o,
  output logic                 test_clk_o,
  output logic                 test_clr_o,
  output logic                 test_en_o,
  output logic [7:0]           test_din_o
);
  localparam int CLR_CYC = CYC_PER_US * CLR_US;
  localparam int CNT_W   = $clog2((CLR_CYC > STEP_CYC ? CLR_CYC : STEP_CYC) + 1) + 1;
  localparam int NENT    = 39;
  localparam logic [LW-1:0] MAXL = LW'(MAX_LANES);

  typedef enum logic [2:0] {S_IDLE, S_SCAN, S_LANE, S_TCK, S_CLR, S_SETTLE, S_WR} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt, lim;
  logic [5:0]       idx, code_q;
  logic [2:0]       ph, wi;
  logic [RATE_W-1:0] rate_q;
  logic [LW-1:0]    lanes_q;
  logic [16:0]      ent;
  logic [MAX_LANES:0] ones;

  function automatic logic [16:0] entry(input logic [5:0] i);
    case (i)
      6'd0:  entry = {11'd89,   6'h00};  6'd1:  entry = {11'd99,   6'h10};
      6'd2:  entry = {11'd109,  6'h20};  6'd3:  entry = {11'd129,  6'h01};
      6'd4:  entry = {11'd139,  6'h11};  6'd5:  entry = {11'd149,  6'h21};
      6'd6:  entry = {11'd169,  6'h02};  6'd7:  entry = {11'd179,  6'h12};
      6'd8:  entry = {11'd199,  6'h22};  6'd9:  entry = {11'd219,  6'h03};
      6'd10: entry = {11'd239,  6'h13};  6'd11: entry = {11'd249,  6'h23};
      6'd12: entry = {11'd269,  6'h04};  6'd13: entry = {11'd299,  6'h14};
      6'd14: entry = {11'd329,  6'h05};  6'd15: entry = {11'd359,  6'h15};
      6'd16: entry = {11'd399,  6'h25};  6'd17: entry = {11'd449,  6'h06};
      6'd18: entry = {11'd499,  6'h16};  6'd19: entry = {11'd549,  6'h07};
      6'd20: entry = {11'd599,  6'h17};  6'd21: entry = {11'd649,  6'h08};
      6'd22: entry = {11'd699,  6'h18};  6'd23: entry = {11'd749,  6'h09};
      6'd24: entry = {11'd799,  6'h19};  6'd25: entry = {11'd849,  6'h29};
      6'd26: entry = {11'd899,  6'h39};  6'd27: entry = {11'd949,  6'h0a};
      6'd28: entry = {11'd999,  6'h1a};  6'd29: entry = {11'd1049, 6'h2a};
      6'd30: entry = {11'd1099, 6'h3a};  6'd31: entry = {11'd1149, 6'h0b};
      6'd32: entry = {11'd1199, 6'h1b};  6'd33: entry = {11'd1249, 6'h2b};
      6'd34: entry = {11'd1299, 6'h3b};  6'd35: entry = {11'd1349, 6'h0c};
      6'd36: entry = {11'd1399, 6'h1c};  6'd37: entry = {11'd1449, 6'h2c};
      default: entry = {11'd1500, 6'h3c};
    endcase
  endfunction

  function automatic logic [7:0] wr_code(input logic [2:0] w);
    case (w)
      3'd0: wr_code = 8'h34;  3'd1: wr_code = 8'h44;  3'd2: wr_code = 8'h54;
      3'd3: wr_code = 8'h84;  3'd4: wr_code = 8'h94;  3'd5: wr_code = 8'h75;
      default: wr_code = 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] wr_data(input logic [2:0] w, input logic [5:0] c);
    case (w)
      3'd1, 3'd2, 3'd3, 3'd4: wr_data = {1'b0, c, 1'b0};
      3'd5:    wr_data = 8'h04;
      default: wr_data = 8'h00;
    endcase
  endfunction

  assign ent  = entry(idx);
  assign lim  = (st == S_CLR || st == S_SETTLE) ? CNT_W'(CLR_CYC) : CNT_W'(STEP_CYC);
  assign ones = ({{MAX_LANES{1'b0}}, 1'b1} << lanes_q) - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; idx <= '0; code_q <= '0; ph <= '0; wi <= '0;
      rate_q <= '0; lanes_q <= '0;
      busy_o <= 1'b0; done_o <= 1'b0; err_o <= 1'b0;
      force_rx_o <= '0; force_stop_o <= '0; turn_req_o <= '0; turn_dis_o <= '0;
      lane_en_o <= '0;
      test_clk_o <= 1'b0; test_clr_o <= 1'b0; test_en_o <= 1'b0; test_din_o <= '0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      if (stop_i) begin
        st <= S_IDLE; busy_o <= 1'b0; lane_en_o <= '0;
        test_en_o <= 1'b0; test_clr_o <= 1'b0; cnt <= '0;
      end else begin
        case (st)
          S_IDLE: if (start_i) begin
            st <= S_SCAN; busy_o <= 1'b1; idx <= '0;
            rate_q <= rate_i; lanes_q <= lanes_i;
          end
          S_SCAN: begin
            if (lanes_q == '0 || lanes_q > MAXL) begin
              err_o <= 1'b1; busy_o <= 1'b0; st <= S_IDLE;
            end else if (32'(ent[16:6]) >= 32'(rate_q)) begin
              if (ent[5:0] == 6'd0) begin
                err_o <= 1'b1; busy_o <= 1'b0; st <= S_IDLE;
              end else begin
                code_q <= ent[5:0]; st <= S_LANE; cnt <= '0;
                force_rx_o <= '0; force_stop_o <= '0; turn_req_o <= '0;
                turn_dis_o <= '1; lane_en_o <= ones[MAX_LANES-1:0];
              end
            end else if (idx == 6'(NENT - 1)) begin
              err_o <= 1'b1; busy_o <= 1'b0; st <= S_IDLE;
            end else begin
              idx <= idx + 1'b1;
            end
          end
          default: begin
            if (cnt != lim - 1'b1) begin
              cnt <= cnt + 1'b1;
            end else begin
              cnt <= '0;
              case (st)
                S_LANE: begin st <= S_TCK; test_clk_o <= 1'b1; end
                S_TCK:  begin st <= S_CLR; test_clr_o <= 1'b1; end
                S_CLR:  begin st <= S_SETTLE; test_clr_o <= 1'b0; end
                S_SETTLE: begin
                  st <= S_WR; ph <= '0; wi <= '0;
                  test_din_o <= wr_code(3'd0); test_en_o <= 1'b1;
                end
                default: begin
                  case (ph)
                    3'd0: test_clk_o <= 1'b0;
                    3'd1: test_en_o  <= 1'b0;
                    3'd2: test_din_o <= wr_data(wi, code_q);
                    3'd3: test_clk_o <= 1'b1;
                    default: ;
                  endcase
                  if (ph != 3'd4) begin
                    ph <= ph + 1'b1;
                  end else if (wi == 3'd6) begin
                    st <= S_IDLE; busy_o <= 1'b0; done_o <= 1'b1;
                  end else begin
                    ph <= '0; wi <= wi + 1'b1;
                    test_din_o <= wr_code(wi + 1'b1); test_en_o <= 1'b1;
                  end
                end
              endcase
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/rxphy_bringup_chk.sv
module rxphy_bringup_chk #(
  parameter int MAX_LANES = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start_i,
  input logic                 stop_i,
  input logic                 busy_o,
  input logic                 done_o,
  input logic                 err_o,
  input logic [MAX_LANES-1:0] lane_en_o,
  input logic                 test_clk_o,
  input logic                 test_clr_o,
  input logic                 test_en_o
);
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  assert_one_outcome_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_o, err_o}));
  assert_reject_keeps_lanes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> $stable(lane_en_o) && !busy_o);
  assert_clear_under_clock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    test_clr_o |-> test_clk_o);
  assert_fall_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(test_clk_o) |-> test_en_o);
  assert_rise_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(test_clk_o) && !test_clr_o && $past(busy_o)) |-> !test_en_o);
  assert_stop_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> (lane_en_o == '0) && !busy_o);
endmodule

bind rxphy_bringup rxphy_bringup_chk #(.MAX_LANES(MAX_LANES)) u_chk (.*);

// File: tb/test_rxphy_bringup.sv
module test_rxphy_bringup;
  localparam int CPU = 2, CLRU = 100, STEP = 3, ML = 4, RW = 11;
  localparam int C = CPU * CLRU;
  localparam int LW = $clog2(ML + 1);

  logic clk = 0, rst_n = 0, start_i = 0, stop_i = 0;
  logic [LW-1:0] lanes_i = '0;
  logic [RW-1:0] rate_i = '0;
  logic busy_o, done_o, err_o, test_clk_o, test_clr_o, test_en_o;
  logic [ML-1:0] force_rx_o, force_stop_o, turn_req_o, turn_dis_o, lane_en_o;
  logic [7:0] test_din_o;

  rxphy_bringup #(.CYC_PER_US(CPU), .CLR_US(CLRU), .STEP_CYC(STEP),
                  .MAX_LANES(ML), .RATE_W(RW)) i_rxphy_bringup (.*);

  always #4 clk = ~clk;

  int n_chk = 0, n_ok = 0;
  int bnd [13][4] = '{'{89,99,109,0},'{129,139,149,0},'{169,179,199,0},'{219,239,249,0},
                      '{269,299,0,0},'{329,359,399,0},'{449,499,0,0},'{549,599,0,0},
                      '{649,699,0,0},'{749,799,849,899},'{949,999,1049,1099},
                      '{1149,1199,1249,1299},'{1349,1399,1449,1500}};

  int npair, seq_bad, clr_run, clr_w, gap, gap_res;
  bit pend, gap_on, p_clk, p_clr;
  logic [7:0] lc, pc [8], pd [8];

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (ok) n_ok++;
    else $display("FAIL %s: actual %0d expected %0d", req, act, exp);
  endtask

  task automatic lookup(int rate, output int k, output int code);
    k = 0; code = -1;
    for (int n = 0; n < 13; n++)
      for (int s = 0; s < 4; s++)
        if (bnd[n][s] != 0 && code < 0) begin
          if (bnd[n][s] >= rate) code = s * 16 + n;
          else k++;
        end
    if (code < 0) k = 38;
  endtask

  always @(negedge clk) begin
    if (test_clr_o) clr_run++;
    if (p_clr && !test_clr_o) begin clr_w = clr_run; gap_on = 1; gap = 0; end
    else if (gap_on) gap++;
    if (p_clk && !test_clk_o) begin
      if (gap_on) begin gap_res = gap; gap_on = 0; end
      if (test_en_o) begin lc = test_din_o; pend = 1; end else seq_bad++;
    end
    if (!p_clk && test_clk_o && pend) begin
      if (test_en_o) seq_bad++;
      if (npair < 8) begin pc[npair] = lc; pd[npair] = test_din_o; end
      npair++; pend = 0;
    end
    p_clk = test_clk_o; p_clr = test_clr_o;
  end

  task automatic run(int rate, int lanes, bit poke);
    int k, code, cyc, expd;
    bit bad;
    logic [ML-1:0] prev_en;
    lookup(rate, k, code);
    bad = (lanes == 0 || lanes > ML || code <= 0);
    if (lanes == 0 || lanes > ML) k = 0;
    npair = 0; pend = 0; seq_bad = 0; clr_run = 0; clr_w = -1; gap_res = -1; gap_on = 0;
    prev_en = lane_en_o;
    @(negedge clk); start_i = 1; rate_i = RW'(rate); lanes_i = LW'(lanes);
    @(negedge clk); start_i = 0;
    cyc = 0;
    while (!done_o && !err_o && cyc < 5000) begin
      @(negedge clk); cyc++;
      if (cyc == 1 && !done_o && !err_o) chk(busy_o, "R8 busy", busy_o, 1);
      if (poke && cyc == 20) begin start_i = 1; lanes_i = 1; end
      if (poke && cyc == 21) start_i = 0;
    end
    expd = k + 1 + (bad ? 0 : 37 * STEP + 2 * C);
    if (cyc >= 5000) chk(0, "watchdog", cyc, expd);
    if (bad) begin
      chk(err_o, "R2 err", err_o, 1);
      chk(cyc == expd, "R2 err latency", cyc, expd);
      chk(lane_en_o == prev_en && npair == 0, "R2 no effect", lane_en_o, prev_en);
    end else begin
      chk(done_o, "R7 done", done_o, 1);
      chk(cyc == expd, "R7 latency", cyc, expd);
      chk(lane_en_o == ML'((1 << lanes) - 1), "R3 lane mask", lane_en_o, (1 << lanes) - 1);
      chk(turn_dis_o == '1 && force_rx_o == 0 && force_stop_o == 0 && turn_req_o == 0,
          "R3 lane controls", turn_dis_o, 15);
      chk(clr_w == C, "R4 clear width", clr_w, C);
      chk(gap_res == C + STEP, "R4 settle", gap_res, C + STEP);
      chk(seq_bad == 0, "R5 handshake", seq_bad, 0);
      chk(npair == 7, "R6 count", npair, 7);
      for (int w = 0; w < 7 && w < npair; w++) begin
        int ec, ed;
        ec = (w == 0) ? 'h34 : (w == 1) ? 'h44 : (w == 2) ? 'h54 : (w == 3) ? 'h84 :
             (w == 4) ? 'h94 : (w == 5) ? 'h75 : 0;
        ed = (w >= 1 && w <= 4) ? code * 2 : (w == 5) ? 4 : 0;
        chk(pc[w] == 8'(ec), "R6 code", pc[w], ec);
        chk(pd[w] == 8'(ed), "R1 data", pd[w], ed);
      end
    end
    chk(!busy_o, "R8 idle", busy_o, 0);
    @(negedge clk);
    chk(!done_o && !err_o, "R8 pulse", done_o, 0);
  endtask

  initial begin
    void'($urandom(32'h1d5e));
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !err_o && lane_en_o == 0 && turn_dis_o == 0 &&
        !test_clk_o && !test_clr_o && !test_en_o && test_din_o == 0, "R10 reset", lane_en_o, 0);
    rst_n = 1;
    @(negedge clk);
    run(90, 4, 0);
    run(89, 2, 0);
    run(0, 1, 0);
    run(1500, 1, 0);
    run(1501, 3, 0);
    run(1449, 2, 1);
    run(130, 0, 0);
    run(500, 5, 0);
    run(899, 3, 0);
    for (int i = 0; i < 10; i++) run($urandom_range(0, 1600), $urandom_range(0, 5), 0);
    // R9: stop in mid-run with a simultaneous start
    @(negedge clk); start_i = 1; rate_i = 700; lanes_i = 4;
    @(negedge clk); start_i = 0;
    repeat (60) @(negedge clk);
    stop_i = 1; start_i = 1;
    @(negedge clk); stop_i = 0; start_i = 0;
    chk(lane_en_o == 0 && !busy_o, "R9 abort", lane_en_o, 0);
    begin
      bit seen;
      seen = 0;
      repeat (2 * C + 200) begin @(negedge clk); if (done_o || busy_o) seen = 1; end
      chk(!seen, "R9 no done", seen, 0);
    end
    run(300, 3, 0);
    @(negedge clk); stop_i = 1;
    @(negedge clk); stop_i = 0;
    chk(lane_en_o == 0, "R9 idle stop", lane_en_o, 0);
    $display("%0d/%0d checks passed", n_ok, n_chk);
    $finish;
  end
endmodule